// File: doc/BRIEF.md
# Warp Issue Scheduler

This block chooses, on every clock cycle, one resident warp to hand its next instruction to the execution pipeline. A warp is a group of lanes (32 by default) that shares one program counter and carries one active-lane mask. The scheduler holds a small record for each warp slot (24 by default): whether the slot is occupied, whether the warp is waiting, its program counter and its lane mask. Moving from one warp to another costs no cycles. Any occupied warp that is not waiting and has at least one live lane may be picked on the next cycle.

The issue outputs come straight from the stored state and from this cycle's stall and exit requests. Create, exit, stall-set, stall-clear and update requests change the stored state at the next rising clock edge. Selection is round-robin. The search starts at the slot after the last warp issued, so every eligible warp is served in turn. The execution side writes back a new program counter and mask after each issue through the update port.

Top module: `warp_sched`

## Requirements
- R1: After reset no slot is occupied and `issueValid` stays low until a warp has been created.
- R2: A create request writes the given PC and mask into the slot, marks it occupied and not waiting, and the warp can issue from the next cycle, showing that PC and mask.
- R3: At most one warp issues per cycle; `issueValid` is low in any cycle in which no warp is eligible, and warp IDs of `NUM_WARPS` or above are ignored on all request ports.
- R4: Among eligible warps the one issued is the first found when counting upward, with wrap-around, from the slot after the last issued warp (after reset the search starts at slot 0).
- R5: A warp marked waiting by a stall-set request is skipped until a stall-clear request for it has taken effect.
- R6: A stall-set request for a warp blocks that warp from issuing in the same cycle as the request.
- R7: A warp whose stored mask is all zero is never issued.
- R8: An exit request clears the slot from the next cycle on and also blocks the warp from issuing in the cycle of the request.
- R9: An update request for an occupied warp replaces its PC and mask from the next cycle; an update for an unoccupied slot has no effect, and the slot stays unissued.
- R10: For one warp in one cycle, stall-set wins over stall-clear and over create, exit wins over create, and create wins over update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| createValid | input | 1 | Create a warp in slot `createWarp` |
| createWarp | input | WID_W | Slot being created |
| createPc | input | PC_W | Starting program counter |
| createMask | input | LANES | Starting active-lane mask |
| exitValid | input | 1 | Retire warp `exitWarp` |
| exitWarp | input | WID_W | Slot being retired |
| stallSetValid | input | 1 | Mark warp `stallSetWarp` as waiting |
| stallSetWarp | input | WID_W | Slot to stall |
| stallClrValid | input | 1 | Release warp `stallClrWarp` |
| stallClrWarp | input | WID_W | Slot to release |
| updValid | input | 1 | Write back PC and mask for `updWarp` |
| updWarp | input | WID_W | Slot being updated |
| updPc | input | PC_W | New program counter |
| updMask | input | LANES | New active-lane mask |
| issueValid | output | 1 | A warp issues this cycle |
| issueWarp | output | WID_W | Issued warp ID |
| issuePc | output | PC_W | Issued program counter (zero when idle) |
| issueMask | output | LANES | Issued lane mask (zero when idle) |

## Verification
The selection of a warp can fall in the same cycle as a stall-set or an exit aimed at that same warp. A write-back update or a create can also land on a slot while another request targets it. The bench provokes these collisions in directed steps, where the selector would otherwise pick the targeted warp. It then provokes them at random, using a small set of warp IDs so that requests often coincide. Each cycle's issue outputs are compared with a reference model that applies the precedence rules of R6, R8 and R10 before the clock edge.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  // per-warp write strobes, resolved by control, consumed by datapath
  typedef struct packed {
    logic create;
    logic kill;
    logic stallSet;
    logic stallClr;
    logic update;
  } warpStrobe_t;
endpackage

// File: rtl/warp_sched_ctrl.sv
module warp_sched_ctrl
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             createValid,
  input  logic [WID_W-1:0] createWarp,
  input  logic             exitValid,
  input  logic [WID_W-1:0] exitWarp,
  input  logic             stallSetValid,
  input  logic [WID_W-1:0] stallSetWarp,
  input  logic             stallClrValid,
  input  logic [WID_W-1:0] stallClrWarp,
  input  logic             updValid,
  input  logic [WID_W-1:0] updWarp,
  input  logic [NUM_WARPS-1:0] eligVec,
  output warpStrobe_t      strobes [NUM_WARPS],
  output logic             issueValid,
  output logic [WID_W-1:0] issueWarp
);

  logic [NUM_WARPS-1:0] blockVec;
  logic [NUM_WARPS-1:0] readyVec;
  logic [WID_W-1:0]     lastPtr;

  // request decode with same-warp precedence
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_dec
    logic hitCreate, hitExit, hitSet, hitClr, hitUpd;
    assign hitCreate = createValid   && (createWarp   == WID_W'(w));
    assign hitExit   = exitValid     && (exitWarp     == WID_W'(w));
    assign hitSet    = stallSetValid && (stallSetWarp == WID_W'(w));
    assign hitClr    = stallClrValid && (stallClrWarp == WID_W'(w));
    assign hitUpd    = updValid      && (updWarp      == WID_W'(w));

    assign strobes[w].kill     = hitExit;
    assign strobes[w].create   = hitCreate && !hitExit;
    assign strobes[w].stallSet = hitSet;
    assign strobes[w].stallClr = hitClr && !hitSet;
    assign strobes[w].update   = hitUpd && !(hitCreate && !hitExit);
    assign blockVec[w]         = hitSet || hitExit;
  end

  assign readyVec = eligVec & ~blockVec;

  // round-robin pick starting after last issued slot
  always_comb begin
    issueValid = 1'b0;
    issueWarp  = '0;
    for (int k = 0; k < NUM_WARPS; k++) begin
      int idx;
      idx = int'(lastPtr) + 1 + k;
      if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
      if (!issueValid && readyVec[idx]) begin
        issueValid = 1'b1;
        issueWarp  = WID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lastPtr <= WID_W'(NUM_WARPS - 1);
    else if (issueValid) lastPtr <= issueWarp;
  end

endmodule

// File: rtl/warp_sched_dp.sv
module warp_sched_dp
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int LANES     = 32,
  parameter int PC_W      = 16,
  parameter int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  warpStrobe_t      strobes [NUM_WARPS],
  input  logic [PC_W-1:0]  createPc,
  input  logic [LANES-1:0] createMask,
  input  logic [PC_W-1:0]  updPc,
  input  logic [LANES-1:0] updMask,
  input  logic             issueValid,
  input  logic [WID_W-1:0] issueWarp,
  output logic [NUM_WARPS-1:0] eligVec,
  output logic [PC_W-1:0]  issuePc,
  output logic [LANES-1:0] issueMask
);

  logic [PC_W-1:0]  pcArr   [NUM_WARPS];
  logic [LANES-1:0] maskArr [NUM_WARPS];

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic             validQ, stallQ;
    logic [PC_W-1:0]  pcQ;
    logic [LANES-1:0] maskQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
        stallQ <= 1'b0;
        pcQ    <= '0;
        maskQ  <= '0;
      end else begin
        if (strobes[w].kill)        validQ <= 1'b0;
        else if (strobes[w].create) validQ <= 1'b1;

        if (strobes[w].stallSet)                           stallQ <= 1'b1;
        else if (strobes[w].create || strobes[w].stallClr) stallQ <= 1'b0;

        if (strobes[w].create) begin
          pcQ   <= createPc;
          maskQ <= createMask;
        end else if (strobes[w].update && validQ) begin
          pcQ   <= updPc;
          maskQ <= updMask;
        end
      end
    end

    assign eligVec[w] = validQ && !stallQ && (|maskQ);
    assign pcArr[w]   = pcQ;
    assign maskArr[w] = maskQ;
  end

  always_comb begin
    issuePc   = '0;
    issueMask = '0;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (issueValid && issueWarp == WID_W'(w)) begin
        issuePc   = pcArr[w];
        issueMask = maskArr[w];
      end
    end
  end

endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int LANES     = 32,
  parameter int PC_W      = 16,
  parameter int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             createValid,
  input  logic [WID_W-1:0] createWarp,
  input  logic [PC_W-1:0]  createPc,
  input  logic [LANES-1:0] createMask,
  input  logic             exitValid,
  input  logic [WID_W-1:0] exitWarp,
  input  logic             stallSetValid,
  input  logic [WID_W-1:0] stallSetWarp,
  input  logic             stallClrValid,
  input  logic [WID_W-1:0] stallClrWarp,
  input  logic             updValid,
  input  logic [WID_W-1:0] updWarp,
  input  logic [PC_W-1:0]  updPc,
  input  logic [LANES-1:0] updMask,
  output logic             issueValid,
  output logic [WID_W-1:0] issueWarp,
  output logic [PC_W-1:0]  issuePc,
  output logic [LANES-1:0] issueMask
);

  warpStrobe_t          strobes [NUM_WARPS];
  logic [NUM_WARPS-1:0] eligVec;

  warp_sched_ctrl #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .createValid(createValid), .createWarp(createWarp),
    .exitValid(exitValid), .exitWarp(exitWarp),
    .stallSetValid(stallSetValid), .stallSetWarp(stallSetWarp),
    .stallClrValid(stallClrValid), .stallClrWarp(stallClrWarp),
    .updValid(updValid), .updWarp(updWarp),
    .eligVec(eligVec), .strobes(strobes),
    .issueValid(issueValid), .issueWarp(issueWarp)
  );

  warp_sched_dp #(.NUM_WARPS(NUM_WARPS), .LANES(LANES), .PC_W(PC_W), .WID_W(WID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .createPc(createPc), .createMask(createMask),
    .updPc(updPc), .updMask(updMask),
    .issueValid(issueValid), .issueWarp(issueWarp),
    .eligVec(eligVec), .issuePc(issuePc), .issueMask(issueMask)
  );

endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int NUM_WARPS = 24,
  parameter int LANES     = 32,
  parameter int WID_W     = $clog2(NUM_WARPS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             issueValid,
  input logic [WID_W-1:0] issueWarp,
  input logic [LANES-1:0] issueMask,
  input logic             stallSetValid,
  input logic [WID_W-1:0] stallSetWarp,
  input logic             exitValid,
  input logic [WID_W-1:0] exitWarp,
  input logic             createValid
);

  // R1: first cycle out of reset has nothing to issue
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !issueValid);

  // R3: issued ID is a real slot
  p_warp_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (int'(issueWarp) < NUM_WARPS));

  // R6: stall request blocks same-cycle issue
  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && stallSetValid) |-> (issueWarp != stallSetWarp));

  // R7: an empty mask is never issued
  p_no_empty_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (issueMask != '0));

  // R8: exit request blocks same-cycle issue
  p_exit_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && exitValid) |-> (issueWarp != exitWarp));

  // R1: without any earlier create nothing can issue
  logic everCreated;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            everCreated <= 1'b0;
    else if (createValid) everCreated <= 1'b1;
  end
  p_no_issue_before_create_r1: assert property (@(posedge clk) disable iff (!rstN)
    !everCreated |-> !issueValid);

endmodule

bind warp_sched warp_sched_chk #(.NUM_WARPS(NUM_WARPS), .LANES(LANES), .WID_W(WID_W)) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueWarp(issueWarp),
  .issueMask(issueMask), .stallSetValid(stallSetValid), .stallSetWarp(stallSetWarp),
  .exitValid(exitValid), .exitWarp(exitWarp), .createValid(createValid)
);

// File: tb/warp_sched_bench.sv
module warp_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;
  localparam int L = 32;
  localparam int P = 16;
  localparam int W = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic createValid, exitValid, stallSetValid, stallClrValid, updValid;
  logic [W-1:0] createWarp, exitWarp, stallSetWarp, stallClrWarp, updWarp;
  logic [P-1:0] createPc, updPc;
  logic [L-1:0] createMask, updMask;
  logic issueValid;
  logic [W-1:0] issueWarp;
  logic [P-1:0] issuePc;
  logic [L-1:0] issueMask;

  int checks = 0;
  int errors = 0;

  // reference state
  bit       mValid [N];
  bit       mStall [N];
  bit [P-1:0] mPc  [N];
  bit [L-1:0] mMask [N];
  int       mLast = N - 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_sched #(.NUM_WARPS(N), .LANES(L), .PC_W(P)) u_warp_sched (
    .clk(clk), .rstN(rstN),
    .createValid(createValid), .createWarp(createWarp), .createPc(createPc), .createMask(createMask),
    .exitValid(exitValid), .exitWarp(exitWarp),
    .stallSetValid(stallSetValid), .stallSetWarp(stallSetWarp),
    .stallClrValid(stallClrValid), .stallClrWarp(stallClrWarp),
    .updValid(updValid), .updWarp(updWarp), .updPc(updPc), .updMask(updMask),
    .issueValid(issueValid), .issueWarp(issueWarp), .issuePc(issuePc), .issueMask(issueMask)
  );

  function automatic bit ready(int w);
    return mValid[w] && !mStall[w] && (mMask[w] != '0) &&
           !(stallSetValid && int'(stallSetWarp) == w) &&
           !(exitValid && int'(exitWarp) == w);
  endfunction

  function automatic int expectPick();
    for (int k = 0; k < N; k++) begin
      int idx = (mLast + 1 + k) % N;
      if (ready(idx)) return idx;
    end
    return -1;
  endfunction

  task automatic clearInputs();
    createValid = 0; exitValid = 0; stallSetValid = 0; stallClrValid = 0; updValid = 0;
    createWarp = '0; exitWarp = '0; stallSetWarp = '0; stallClrWarp = '0; updWarp = '0;
    createPc = '0; createMask = '0; updPc = '0; updMask = '0;
  endtask

  task automatic check(string tag, bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic modelUpdate(int pick);
    for (int w = 0; w < N; w++) begin
      bit cr = createValid && int'(createWarp) == w && !(exitValid && int'(exitWarp) == w);
      bit ki = exitValid && int'(exitWarp) == w;
      bit st = stallSetValid && int'(stallSetWarp) == w;
      bit cl = stallClrValid && int'(stallClrWarp) == w;
      bit up = updValid && int'(updWarp) == w && !cr && mValid[w];
      if (cr) begin mPc[w] = createPc; mMask[w] = createMask; end
      else if (up) begin mPc[w] = updPc; mMask[w] = updMask; end
      if (st) mStall[w] = 1;
      else if (cr || cl) mStall[w] = 0;
      if (ki) mValid[w] = 0;
      else if (cr) mValid[w] = 1;
    end
    if (pick >= 0) mLast = pick;
  endtask

  // inputs already driven after the falling edge
  task automatic step(string tag);
    int pick;
    #1;
    pick = expectPick();
    check(tag, issueValid == (pick >= 0), "issueValid", issueValid, pick >= 0);
    if (pick >= 0 && issueValid) begin
      check(tag, int'(issueWarp) == pick, "issueWarp", issueWarp, pick);
      check(tag, issuePc == mPc[pick], "issuePc", issuePc, mPc[pick]);
      check(tag, issueMask == mMask[pick], "issueMask", issueMask, mMask[pick]);
    end
    modelUpdate(pick);
    @(negedge clk);
    clearInputs();
  endtask

  task automatic doCreate(int w, int pc, logic [L-1:0] m, string tag);
    createValid = 1; createWarp = W'(w); createPc = P'(pc); createMask = m;
    step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int w = 0; w < N; w++) begin mValid[w] = 0; mStall[w] = 0; mPc[w] = 0; mMask[w] = 0; end
    clearInputs();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: nothing resident after reset
    step("R1"); step("R1");
    // R2: create, then issue with stored PC and mask
    doCreate(3, 'h100, '1, "R2");
    step("R2");
    doCreate(5, 'h200, 32'h0000_00ff, "R2");
    doCreate(7, 'h300, 32'h8000_0001, "R4");
    // R4: round-robin order 3,5,7,3...
    repeat (4) step("R4");
    // R5: stall warp 5, skipped until cleared
    stallSetValid = 1; stallSetWarp = 5; step("R5");
    repeat (3) step("R5");
    stallClrValid = 1; stallClrWarp = 5; step("R5");
    repeat (3) step("R5");
    // R6: stall request for the warp next in line
    stallSetValid = 1; stallSetWarp = W'((mLast + 1) % N == 4 ? 5 : 3); step("R6");
    stallClrValid = 1; stallClrWarp = 3; step("R6");
    stallClrValid = 1; stallClrWarp = 5; step("R6");
    // R7: empty mask never issued
    doCreate(9, 'h400, '0, "R7");
    repeat (4) step("R7");
    // R9: update occupied warp and unoccupied slot
    updValid = 1; updWarp = 9; updPc = 'h444; updMask = 32'h0000_0f00; step("R9");
    updValid = 1; updWarp = 20; updPc = 'h555; updMask = '1; step("R9");
    repeat (5) step("R9");
    // R8: exit blocks same cycle and clears slot
    exitValid = 1; exitWarp = 7; step("R8");
    repeat (4) step("R8");
    // R10: set beats clear, exit beats create, create beats update
    stallSetValid = 1; stallSetWarp = 3; stallClrValid = 1; stallClrWarp = 3; step("R10");
    repeat (3) step("R10");
    createValid = 1; createWarp = 11; createPc = 'h600; createMask = '1;
    exitValid = 1; exitWarp = 11; step("R10");
    repeat (2) step("R10");
    createValid = 1; createWarp = 12; createPc = 'h700; createMask = 32'h3;
    updValid = 1; updWarp = 12; updPc = 'h7ff; updMask = 32'hc; step("R10");
    repeat (2) step("R10");
    // R3: stall every resident warp, nothing issues; out-of-range ID ignored
    for (int w = 0; w < N; w++) begin
      if (mValid[w]) begin stallSetValid = 1; stallSetWarp = W'(w); step("R3"); end
    end
    createValid = 1; createWarp = W'(N + 2); createPc = 'h1; createMask = '1; step("R3");
    repeat (3) step("R3");

    // random collisions over a small ID set
    for (int i = 0; i < 4000; i++) begin
      createValid   = ($urandom_range(0, 3) == 0);
      createWarp    = W'($urandom_range(0, 7));
      createPc      = P'($urandom);
      createMask    = ($urandom_range(0, 7) == 0) ? '0 : L'($urandom);
      exitValid     = ($urandom_range(0, 7) == 0);
      exitWarp      = W'($urandom_range(0, 7));
      stallSetValid = ($urandom_range(0, 3) == 0);
      stallSetWarp  = W'($urandom_range(0, 7));
      stallClrValid = ($urandom_range(0, 2) == 0);
      stallClrWarp  = W'($urandom_range(0, 7));
      updValid      = ($urandom_range(0, 2) == 0);
      updWarp       = W'($urandom_range(0, 7));
      updPc         = P'($urandom);
      updMask       = L'($urandom);
      step("R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule